// File: doc/BRIEF.md
# Slot-Sized Memory Window Decoder

This block holds two memory base address registers for a bridge target and decodes bus addresses against them. The first register opens a window over up to six populated slots. Each slot is a 128 KB region, and slot n starts at byte offset n×20000h from the base. The window size is the slot count rounded up to a power of two times 128 KB, and the count is an input that can change at run time. When software writes all ones and reads the register back, it sees the size mask for the current slot count. An address inside the window is split into a slot index and a 16-bit word offset. If that slot is not populated, the decoder flags a target abort instead of a hit.

The second register opens a fixed 4 KB window. This window holds a peripheral register area and a small control register area. For each access the decoder reports which area was hit and the dword index inside it. Configuration writes and reads go through a select input and a combinational read data port. Address decode is fully combinational from the access address, the stored bases and the memory-space enable.

Top module: `slot_bar_decoder`

## Requirements
- R1: After reset both base registers read back 00000000h, and no hit, abort or region flag is raised.
- R2: After all ones are written to the slot register (cfg_sel=0), it reads FFFE0000h for a count of 1, FFFC0000h for 2, FFF80000h for 3 or 4, and FFF00000h for 5 or 6. A count of 0 reads as if it were 1, and a count of 7 reads as if it were 6.
- R3: The slot register keeps only the address bits above the current window size, so bits 3:0 always read 0 (memory space, 32-bit decode, non-prefetchable). For example, writing 40012345h with 3 slots reads back 40000000h.
- R4: An access whose upper bits match the slot base under the size mask raises slot_hit. It gives slot_idx = address bits 19:17, taken within the window, and slot_word = address bits 16:1.
- R5: An access inside the slot window whose slot index is at or above the effective slot count raises slot_abort and not slot_hit. An access outside the window raises neither.
- R6: With mem_en low or acc_valid low, no hit, abort or region flag is raised.
- R7: After all ones are written to the register window register (cfg_sel=1), it reads FFFFF000h. An access hits (reg_hit) when address bits 31:12 equal the stored base.
- R8: In the register window, offsets 000h to 5FFh raise reg_periph, with periph_idx = offset bits 10:2.
- R9: In the register window, offsets 800h to 81Fh raise reg_ctrl, with ctrl_idx = offset bits 4:2. Any other offset in the window raises reg_hit with neither region flag, so the access has no target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slot_count | input | 3 | Number of populated slots |
| mem_en | input | 1 | Memory-space enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the slot register, 1 selects the register window register |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Readback of the selected register |
| acc_valid | input | 1 | Access address valid |
| acc_addr | input | 32 | Access byte address |
| slot_hit | output | 1 | Access targets a populated slot |
| slot_abort | output | 1 | Access targets an unpopulated slot in the window |
| slot_idx | output | 3 | Slot index of the access |
| slot_word | output | 16 | Word offset inside the slot |
| reg_hit | output | 1 | Access falls in the register window |
| reg_periph | output | 1 | Access targets the peripheral register area |
| reg_ctrl | output | 1 | Access targets the control register area |
| periph_idx | output | 9 | Dword index in the peripheral area |
| ctrl_idx | output | 3 | Dword index in the control area |

## Verification
The sizing probe is repeated for every slot count from 0 to 7. This separates the rounding to a power of two from plain linear sizing, and it shows how the out-of-range counts are clamped. Addresses are then placed on slot boundaries, on the last populated slot, on the first hole, and just past the window, for 3, 5 and 6 slots. This tells a hit apart from an abort and from a miss. Register-window addresses sit on the first and last entries of each area and on the gaps around them, so any off-by-one range bound shows up. Toggling the enable and writing a base that is not aligned cover the gating and the masked storage.

// File: rtl/slot_bar_decoder.sv
module slot_bar_decoder #(
  parameter int ADDR_W    = 32,
  parameter int SLOT_AW   = 17,
  parameter int MAX_SLOTS = 6,
  parameter int REG_AW    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           slot_count,
  input  logic                 mem_en,
  input  logic                 cfg_wr,
  input  logic                 cfg_sel,
  input  logic [ADDR_W-1:0]    cfg_wdata,
  output logic [ADDR_W-1:0]    cfg_rdata,
  input  logic                 acc_valid,
  input  logic [ADDR_W-1:0]    acc_addr,
  output logic                 slot_hit,
  output logic                 slot_abort,
  output logic [2:0]           slot_idx,
  output logic [SLOT_AW-2:0]   slot_word,
  output logic                 reg_hit,
  output logic                 reg_periph,
  output logic                 reg_ctrl,
  output logic [8:0]           periph_idx,
  output logic [2:0]           ctrl_idx
);
  localparam int IDX_W       = 3;
  localparam int PERIPH_LAST = 12'h5FF;
  localparam logic [6:0] CTRL_TAG = 7'b1000000;

  logic [ADDR_W-1:SLOT_AW] slot_base;
  logic [ADDR_W-1:REG_AW]  reg_base;
  logic [IDX_W-1:0]        n_eff;
  logic [IDX_W-1:0]        lg;
  logic [ADDR_W-1:0]       mask;
  logic [IDX_W-1:0]        idx_raw;
  logic                    live;
  logic                    in_win;
  logic [REG_AW-1:0]       roff;

  always_comb begin
    if (slot_count == '0) n_eff = 3'd1;
    else if (32'(slot_count) > MAX_SLOTS) n_eff = IDX_W'(MAX_SLOTS);
    else n_eff = slot_count;
    lg = '0;
    for (int k = 0; k < IDX_W; k++)
      if ((32'd1 << lg) < 32'(n_eff)) lg = lg + 1'b1;
  end

  assign mask = {ADDR_W{1'b1}} << (SLOT_AW + int'(lg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_base <= '0;
      reg_base  <= '0;
    end else if (cfg_wr) begin
      if (cfg_sel) reg_base  <= cfg_wdata[ADDR_W-1:REG_AW];
      else         slot_base <= cfg_wdata[ADDR_W-1:SLOT_AW] & mask[ADDR_W-1:SLOT_AW];
    end
  end

  assign cfg_rdata = cfg_sel ? {reg_base, {REG_AW{1'b0}}}
                             : ({slot_base, {SLOT_AW{1'b0}}} & mask);

  assign live       = mem_en && acc_valid;
  assign in_win     = live && ((acc_addr & mask) == ({slot_base, {SLOT_AW{1'b0}}} & mask));
  assign idx_raw    = acc_addr[SLOT_AW +: IDX_W] & ~mask[SLOT_AW +: IDX_W];
  assign slot_idx   = idx_raw;
  assign slot_word  = acc_addr[SLOT_AW-1:1];
  assign slot_hit   = in_win && (idx_raw < n_eff);
  assign slot_abort = in_win && !(idx_raw < n_eff);

  assign roff       = acc_addr[REG_AW-1:0];
  assign reg_hit    = live && (acc_addr[ADDR_W-1:REG_AW] == reg_base);
  assign reg_periph = reg_hit && (32'(roff) <= PERIPH_LAST);
  assign reg_ctrl   = reg_hit && (roff[REG_AW-1:5] == CTRL_TAG);
  assign periph_idx = roff[10:2];
  assign ctrl_idx   = roff[4:2];

  logic [ADDR_W-1:0] rd_neg;
  assign rd_neg = ~cfg_rdata + 1'b1;

  p_size_pow2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_sel && (&cfg_wdata)) ##1 (!cfg_sel && $stable(slot_count))
      |-> ($countones(rd_neg) == 1));

  p_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[3:0] == 4'h0);

  p_hit_abort_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_hit && slot_abort));

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_hit || slot_abort || reg_hit) |-> (mem_en && acc_valid));

  p_reg_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && cfg_sel && $past(cfg_sel) && !$past(cfg_wr)) |-> $stable(cfg_rdata));

  p_region_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_periph && reg_ctrl));

  p_region_in_win_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_periph || reg_ctrl) |-> reg_hit);
endmodule

// File: tb/slot_bar_decoder_tb.sv
module slot_bar_decoder_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  slot_count = 3'd1;
  logic        mem_en = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        slot_hit, slot_abort, reg_hit, reg_periph, reg_ctrl;
  logic [2:0]  slot_idx, ctrl_idx;
  logic [15:0] slot_word;
  logic [8:0]  periph_idx;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  slot_bar_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .slot_count(slot_count), .mem_en(mem_en),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr),
    .slot_hit(slot_hit), .slot_abort(slot_abort), .slot_idx(slot_idx), .slot_word(slot_word),
    .reg_hit(reg_hit), .reg_periph(reg_periph), .reg_ctrl(reg_ctrl),
    .periph_idx(periph_idx), .ctrl_idx(ctrl_idx)
  );

  localparam logic [31:0] SIZE_EXP [0:7] = '{
    32'hFFFE0000, 32'hFFFE0000, 32'hFFFC0000, 32'hFFF80000,
    32'hFFF80000, 32'hFFF00000, 32'hFFF00000, 32'hFFF00000
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_sel = sel; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
  endtask

  task automatic slot_acc(input string req, input logic [31:0] a,
                          input logic eh, input logic ea, input logic [2:0] ei, input logic [15:0] ew);
    @(negedge clk);
    acc_addr = a; acc_valid = 1'b1;
    #1;
    chk(req, {14'd0, slot_hit, slot_abort, slot_word}, {14'd0, eh, ea, ew});
    if (eh || ea) chk(req, {29'd0, slot_idx}, {29'd0, ei});
  endtask

  task automatic reg_acc(input string req, input logic [31:0] a, input logic eh,
                         input logic ep, input logic ec, input logic [8:0] pi, input logic [2:0] ci);
    @(negedge clk);
    acc_addr = a; acc_valid = 1'b1;
    #1;
    chk(req, {29'd0, reg_hit, reg_periph, reg_ctrl}, {29'd0, eh, ep, ec});
    if (ep) chk(req, {23'd0, periph_idx}, {23'd0, pi});
    if (ec) chk(req, {29'd0, ctrl_idx}, {29'd0, ci});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    mem_en = 1'b1; acc_valid = 1'b1; acc_addr = 32'h0000_0000;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    cfg_sel = 1'b0; #1; chk("R1 slot bar", cfg_rdata, 32'h0);
    cfg_sel = 1'b1; #1; chk("R1 reg bar", cfg_rdata, 32'h0);
    mem_en = 1'b0; #1;
    chk("R1 flags", {27'd0, slot_hit, slot_abort, reg_hit, reg_periph, reg_ctrl}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R2 sizing table walk over every count
    for (int n = 0; n < 8; n++) begin
      @(negedge clk); slot_count = 3'(n);
      cfg_write(1'b0, 32'hFFFF_FFFF);
      chk($sformatf("R2 size count=%0d", n), cfg_rdata, SIZE_EXP[n]);
    end

    // R3 masked storage
    slot_count = 3'd3;
    cfg_write(1'b0, 32'h4001_2345);
    chk("R3 masked base", cfg_rdata, 32'h4000_0000);
    chk("R3 low bits", {28'd0, cfg_rdata[3:0]}, 32'h0);

    // R4 / R5 with 3 slots
    mem_en = 1'b1;
    slot_acc("R4 slot0 start", 32'h4000_0000, 1, 0, 3'd0, 16'h0000);
    slot_acc("R4 slot2 word1", 32'h4004_0002, 1, 0, 3'd2, 16'h0001);
    slot_acc("R4 slot1 last",  32'h4003_FFFE, 1, 0, 3'd1, 16'hFFFF);
    slot_acc("R5 hole slot3",  32'h4006_0000, 0, 1, 3'd3, 16'h0000);
    slot_acc("R5 outside",     32'h4008_0000, 0, 0, 3'd0, 16'h0000);

    // 5 slots
    slot_count = 3'd5;
    cfg_write(1'b0, 32'h4000_0000);
    slot_acc("R4 slot4",       32'h4008_0010, 1, 0, 3'd4, 16'h0008);
    slot_acc("R5 hole slot5",  32'h400A_0000, 0, 1, 3'd5, 16'h0000);
    // 6 slots
    slot_count = 3'd6;
    slot_acc("R4 slot5 pop",   32'h400A_0000, 1, 0, 3'd5, 16'h0000);
    slot_acc("R5 hole slot6",  32'h400C_0000, 0, 1, 3'd6, 16'h0000);
    slot_acc("R5 hole slot7",  32'h400E_0000, 0, 1, 3'd7, 16'h0000);
    slot_acc("R5 past window", 32'h4010_0000, 0, 0, 3'd0, 16'h0000);

    // R6 gating
    @(negedge clk); mem_en = 1'b0; acc_addr = 32'h4000_0000; #1;
    chk("R6 mem_en low", {30'd0, slot_hit, slot_abort}, 32'h0);
    @(negedge clk); mem_en = 1'b1; acc_valid = 1'b0; acc_addr = 32'h400C_0000; #1;
    chk("R6 valid low", {30'd0, slot_hit, slot_abort}, 32'h0);
    mem_en = 1'b1;

    // R7 register window
    cfg_write(1'b1, 32'hFFFF_FFFF);
    chk("R7 size", cfg_rdata, 32'hFFFF_F000);
    cfg_write(1'b1, 32'h8000_0ABC);
    chk("R7 base", cfg_rdata, 32'h8000_0000);
    reg_acc("R7 miss",        32'h8000_1000, 0, 0, 0, 9'd0, 3'd0);
    reg_acc("R8 periph first",32'h8000_0000, 1, 1, 0, 9'd0, 3'd0);
    reg_acc("R8 periph mid",  32'h8000_0400, 1, 1, 0, 9'h100, 3'd0);
    reg_acc("R8 periph last", 32'h8000_05FC, 1, 1, 0, 9'h17F, 3'd0);
    reg_acc("R9 gap 600",     32'h8000_0600, 1, 0, 0, 9'd0, 3'd0);
    reg_acc("R9 gap 7FC",     32'h8000_07FC, 1, 0, 0, 9'd0, 3'd0);
    reg_acc("R9 ctrl first",  32'h8000_0800, 1, 0, 1, 9'd0, 3'd0);
    reg_acc("R9 ctrl last",   32'h8000_081C, 1, 0, 1, 9'd0, 3'd7);
    reg_acc("R9 gap 820",     32'h8000_0820, 1, 0, 0, 9'd0, 3'd0);
    @(negedge clk); mem_en = 1'b0; acc_addr = 32'h8000_0400; #1;
    chk("R6 reg gate", {29'd0, reg_hit, reg_periph, reg_ctrl}, 32'h0);

    // R1 reset again clears programmed bases
    @(negedge clk); rst_n = 1'b0; #1;
    cfg_sel = 1'b1; #1; chk("R1 reg bar after reset", cfg_rdata, 32'h0);
    cfg_sel = 1'b0; #1; chk("R1 slot bar after reset", cfg_rdata, 32'h0);
    @(negedge clk);
    finish_run();
  end
endmodule